// File: doc/BRIEF.md
# Oversampled PWM Stereo Audio Output

This block turns a stream of 16-bit signed stereo sample pairs into two one-bit pulse-width-modulated pins. Each pin can drive a simple amplifier stage directly, with no converter chip in between. A master clock is divided by a programmable prescaler. Each divided tick advances a shared phase counter. Each output is high from the start of every PWM period until the phase reaches that channel's duty level.

A 32-bit control word sets the block's behaviour. It holds an enable, a soft reset, an oversample select (ratio 32 or 64) and an 8-bit divider field. The PWM period spans twice the oversample ratio in divided ticks. Every sample's pattern repeats for eight periods before the next pair is taken. Software therefore picks the divider so that the master clock equals oversample ratio × sample rate × 2 × divider × 8, which gives 44.1 kHz or 48 kHz audio. No pop or click suppression and no noise shaping is performed.

Top module: `pwm_audio_out`

## Requirements
- R1: Control word fields: bit 28 is enable, bit 24 is soft reset, bit 20 selects the oversample ratio (0 gives 32, 1 gives 64), and bits 7:0 hold the divide value minus one (divide 1 to 256). All other bits have no effect.
- R2: While enable is 0 or soft reset is 1, both outputs are low from the next clock edge on, and all counters are cleared. Soft reset overrides enable. After reset both outputs are low.
- R3: With divide value D and oversample ratio N, one PWM period lasts 2·N·D master clocks. Each output goes high at the start of a period and stays high for exactly level·D clocks.
- R4: The duty level is taken from the sample with its top bit inverted (offset binary). The top 6 bits are used when N is 32, and the top 7 bits when N is 64. A zero sample gives a 50 % duty cycle. The most negative sample gives a level of 0, so the output stays low.
- R5: A loaded pair plays for exactly 8 consecutive periods. A new pair is loaded only at such an 8-period frame boundary, or on the first cycle after the block becomes enabled, so a period is never cut short.
- R6: A sample pair is captured into a holding register on every cycle where sampleValid is 1, whether or not the block is enabled. The most recent capture before a frame boundary is the one loaded.
- R7: Both channels share one prescaler and one phase counter. When both levels are nonzero, the outputs rise on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrlWord | input | 32 | Control word: enable, soft reset, oversample select, divider |
| sampleValid | input | 1 | Capture strobe for the sample pair |
| sampleLeft | input | 16 | Left sample, two's complement |
| sampleRight | input | 16 | Right sample, two's complement |
| pwmLeft | output | 1 | Left PWM output |
| pwmRight | output | 1 | Right PWM output |

## Verification
The hardest situation to reach from the ports is a sample arriving while the previous pair is still playing. The bench must show that the pulse train only changes at an 8-period frame boundary, and that the last of several captures wins. The driver derives the frame length from the control word. It presents each new pair in the middle of a frame, or twice within one frame, and queues eight expected pulse widths per channel. A monitor measures every high pulse and compares it in order. A disabled-while-loaded sequence and a soft reset with enable held high cover the idle behaviour.

// File: rtl/pwmo_pkg.sv
package pwmo_pkg;
  // strobes sent from the sequencing control to the datapath
  typedef struct packed {
    logic run;   // enabled and not in soft reset
    logic live;  // counters are running (one cycle behind run)
    logic tick;  // divided clock tick
    logic load;  // take the pending pair into the active levels
  } pwmStrobe_t;
endpackage

// File: rtl/pwmo_ctrl.sv
module pwmo_ctrl
  import pwmo_pkg::*;
#(
  parameter int CTRL_W   = 32,
  parameter int DIV_W    = 8,
  parameter int OSR_LOG  = 5,
  parameter int REPEAT   = 8,
  parameter int EN_BIT   = 28,
  parameter int SRST_BIT = 24,
  parameter int OS_BIT   = 20,
  localparam int CNT_W   = OSR_LOG + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrlWord,
  output pwmStrobe_t        strb,
  output logic [CNT_W-1:0]  phase,
  output logic              osSel
);
  localparam int REP_W = (REPEAT > 1) ? $clog2(REPEAT) : 1;
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'((1 << (CNT_W - 1)) - 1);
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'((1 << CNT_W) - 1);

  logic             runEn;
  logic             live;
  logic [DIV_W-1:0] divField;
  logic [DIV_W-1:0] preCnt;
  logic [REP_W-1:0] repCnt;
  logic             tick;
  logic             phaseLast;
  logic             repLast;
  logic             load;

  assign runEn    = ctrlWord[EN_BIT] & ~ctrlWord[SRST_BIT];
  assign osSel    = ctrlWord[OS_BIT];
  assign divField = ctrlWord[DIV_W-1:0];

  assign tick      = live & (preCnt >= divField);
  assign phaseLast = phase == (osSel ? LAST_WIDE : LAST_NARROW);
  assign repLast   = repCnt == REP_W'(REPEAT - 1);
  assign load      = runEn & (~live | (tick & phaseLast & repLast));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live   <= 1'b0;
      preCnt <= '0;
      phase  <= '0;
      repCnt <= '0;
    end else if (!runEn) begin
      live   <= 1'b0;
      preCnt <= '0;
      phase  <= '0;
      repCnt <= '0;
    end else begin
      live <= 1'b1;
      if (live) begin
        if (tick) begin
          preCnt <= '0;
          if (phaseLast) begin
            phase  <= '0;
            repCnt <= repLast ? '0 : repCnt + 1'b1;
          end else begin
            phase <= phase + 1'b1;
          end
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end
    end
  end

  assign strb = '{run: runEn, live: live, tick: tick, load: load};

  // R2: leaving the run state clears the sequencing state
  p_idle_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !runEn |=> (phase == '0 && repCnt == '0 && preCnt == '0 && !live));

  // R5: after a load every counter restarts a fresh frame
  p_load_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (phase == '0 && repCnt == '0 && preCnt == '0));

  // R3: phase advances by one on a tick inside a period
  p_phase_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (runEn && tick && !phaseLast) |=> (phase == $past(phase) + 1'b1));

  // R3: phase holds between ticks
  p_phase_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (runEn && live && !tick) |=> $stable(phase));
endmodule

// File: rtl/pwmo_datapath.sv
module pwmo_datapath
  import pwmo_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int OSR_LOG  = 5,
  parameter int CHANNELS = 2,
  localparam int CNT_W   = OSR_LOG + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  pwmStrobe_t          strb,
  input  logic [CNT_W-1:0]    phase,
  input  logic                osSel,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleIn [CHANNELS],
  output logic                pwmOut [CHANNELS]
);
  function automatic logic [CNT_W-1:0] toLevel(input logic [SAMPLE_W-1:0] s,
                                               input logic wide);
    logic [SAMPLE_W-1:0] u;
    u = {~s[SAMPLE_W-1], s[SAMPLE_W-2:0]};
    if (wide) return u[SAMPLE_W-1 -: CNT_W];
    return {1'b0, u[SAMPLE_W-1 -: CNT_W-1]};
  endfunction

  logic [SAMPLE_W-1:0] pending [CHANNELS];
  logic [CNT_W-1:0]    level   [CHANNELS];

  for (genvar g = 0; g < CHANNELS; g++) begin : gChan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pending[g] <= '0;
        level[g]   <= '0;
        pwmOut[g]  <= 1'b0;
      end else begin
        if (sampleValid) pending[g] <= sampleIn[g];
        if (strb.load)   level[g]   <= toLevel(pending[g], osSel);
        pwmOut[g] <= strb.run & strb.live & (phase < level[g]);
      end
    end

    // R2: outputs drop once the block stops running
    p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !strb.run |=> !pwmOut[g]);

    // R4: a zero level keeps the pin low
    p_zero_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (level[g] == '0) |=> !pwmOut[g]);

    // R5: active level changes only through a load
    p_level_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !strb.load |=> $stable(level[g]));

    // R3: a pulse begins only at phase zero
    p_rise_at_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwmOut[g]) |-> $past(phase) == '0);
  end

  // R7: channels rise together when both carry a pulse
  if (CHANNELS > 1) begin : gLock
    p_lockstep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pwmOut[0]) && level[1] != '0) |-> $rose(pwmOut[1]));
  end
endmodule

// File: rtl/pwm_audio_out.sv
module pwm_audio_out #(
  parameter int CTRL_W   = 32,
  parameter int SAMPLE_W = 16,
  parameter int DIV_W    = 8,
  parameter int OSR_LOG  = 5,
  parameter int REPEAT   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CTRL_W-1:0]   ctrlWord,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleLeft,
  input  logic [SAMPLE_W-1:0] sampleRight,
  output logic                pwmLeft,
  output logic                pwmRight
);
  import pwmo_pkg::*;
  localparam int CNT_W = OSR_LOG + 2;

  pwmStrobe_t          strb;
  logic [CNT_W-1:0]    phase;
  logic                osSel;
  logic [SAMPLE_W-1:0] samples [2];
  logic                pins    [2];

  assign samples[0] = sampleLeft;
  assign samples[1] = sampleRight;
  assign pwmLeft    = pins[0];
  assign pwmRight   = pins[1];

  pwmo_ctrl #(
    .CTRL_W (CTRL_W),
    .DIV_W  (DIV_W),
    .OSR_LOG(OSR_LOG),
    .REPEAT (REPEAT)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrlWord(ctrlWord),
    .strb    (strb),
    .phase   (phase),
    .osSel   (osSel)
  );

  pwmo_datapath #(
    .SAMPLE_W(SAMPLE_W),
    .OSR_LOG (OSR_LOG),
    .CHANNELS(2)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .phase      (phase),
    .osSel      (osSel),
    .sampleValid(sampleValid),
    .sampleIn   (samples),
    .pwmOut     (pins)
  );
endmodule

// File: tb/pwm_audio_out_bench.sv
module pwm_audio_out_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctrlWord = '0;
  logic        sampleValid = 1'b0;
  logic [15:0] sampleLeft = '0;
  logic [15:0] sampleRight = '0;
  logic        pwmLeft, pwmRight;

  always #5 clk = ~clk;

  pwm_audio_out u_pwm_audio_out (
    .clk(clk), .rst_n(rst_n), .ctrlWord(ctrlWord), .sampleValid(sampleValid),
    .sampleLeft(sampleLeft), .sampleRight(sampleRight),
    .pwmLeft(pwmLeft), .pwmRight(pwmRight));

  int checks = 0;
  int fails  = 0;
  int qL[$];
  int qR[$];
  bit monOn = 0;
  bit lockOn = 0;
  int runL = 0, runR = 0, lockMiss = 0;
  bit prevL = 0, prevR = 0;
  int frameLen = 1024;

  localparam logic [31:0] EN = 32'h1000_0000;
  localparam logic [31:0] SR = 32'h0100_0000;
  localparam logic [31:0] OS = 32'h0010_0000;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R4 mapping and R3 width computed from the requirement text
  function automatic int pulseLen(input logic [15:0] s, input logic [31:0] c);
    logic [15:0] u;
    int lvl;
    u = s ^ 16'h8000;
    lvl = c[20] ? int'(u >> 9) : int'(u >> 10);
    return lvl * (int'(c[7:0]) + 1);
  endfunction

  task automatic pushFrame(input logic [15:0] l, input logic [15:0] r, input logic [31:0] c);
    for (int i = 0; i < 8; i++) begin
      if (pulseLen(l, c) > 0) qL.push_back(pulseLen(l, c));
      if (pulseLen(r, c) > 0) qR.push_back(pulseLen(r, c));
    end
  endtask

  task automatic present(input logic [15:0] l, input logic [15:0] r);
    sampleLeft = l; sampleRight = r; sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic startRun(input logic [31:0] c, input logic [15:0] l, input logic [15:0] r);
    frameLen = 16 * (c[20] ? 64 : 32) * (int'(c[7:0]) + 1);
    @(negedge clk);
    present(l, r);
    pushFrame(l, r, c);
    monOn = 1;
    ctrlWord = c;
  endtask

  task automatic feed(input logic [31:0] c, input logic [15:0] l, input logic [15:0] r);
    repeat (frameLen / 2) @(negedge clk);
    present(l, r);
    pushFrame(l, r, c);
    repeat (frameLen / 2 - 1) @(negedge clk);
  endtask

  task automatic endRun(input string tag);
    repeat (frameLen + frameLen / 4) @(negedge clk);
    monOn = 0;
    chk(qL.size() == 0, {tag, " left pulses all seen"}, qL.size(), 0);
    chk(qR.size() == 0, {tag, " right pulses all seen"}, qR.size(), 0);
    qL.delete(); qR.delete();
    ctrlWord = '0;
    repeat (3) @(negedge clk);
    chk(!pwmLeft && !pwmRight, "R2 low after disable", {pwmLeft, pwmRight}, 0);
  endtask

  // monitor: measures each high pulse and compares with the queue
  always @(negedge clk) begin
    if (!monOn) begin
      runL = 0; runR = 0;
    end else begin
      if (lockOn && pwmLeft && !prevL && !(pwmRight && !prevR)) lockMiss++;
      if (pwmLeft) runL++;
      else if (runL > 0) begin
        if (qL.size() > 0) begin
          int e;
          e = qL.pop_front();
          chk(runL == e, "R3/R4/R5 left pulse width", runL, e);
        end
        runL = 0;
      end
      if (pwmRight) runR++;
      else if (runR > 0) begin
        if (qR.size() > 0) begin
          int e;
          e = qR.pop_front();
          chk(runR == e, "R3/R4/R5 right pulse width", runR, e);
        end
        runR = 0;
      end
    end
    prevL = pwmLeft; prevR = pwmRight;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] c;
    int highs;
    repeat (3) @(negedge clk);
    chk(!pwmLeft && !pwmRight, "R2 reset state", {pwmLeft, pwmRight}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // case A: ratio 32, divide 2, several pairs (R1 R3 R4 R5 R7)
    c = EN | 32'd1;
    lockOn = 1;
    startRun(c, 16'h0000, 16'h4000);
    feed(c, 16'hC000, 16'h7FFF);
    feed(c, 16'h8400, 16'h0000);
    endRun("R5 caseA");
    lockOn = 0;
    chk(lockMiss == 0, "R7 left rise without right rise", lockMiss, 0);

    // case B: two captures in one frame, the last wins (R6)
    startRun(c, 16'h1000, 16'hF000);
    repeat (frameLen / 4) @(negedge clk);
    present(16'h4000, 16'h4000);
    repeat (frameLen / 4) @(negedge clk);
    present(16'hC000, 16'hC000);
    pushFrame(16'hC000, 16'hC000, c);
    repeat (frameLen / 2 - 2) @(negedge clk);
    endRun("R6 caseB");

    // case C: ratio 64, divide 1, unrelated bits set (R1 R4)
    c = EN | OS | 32'h4000_0F00;
    startRun(c, 16'h1234, 16'h0000);
    feed(c, 16'h8000, 16'h7FFF);
    endRun("R1 caseC");

    // case D: divide 3 (R1 R3)
    c = EN | 32'd2;
    startRun(c, 16'h2000, 16'hE000);
    endRun("R3 caseD");

    // case E: most negative sample keeps both pins low (R4)
    c = EN | 32'd1;
    startRun(c, 16'h8000, 16'h8000);
    highs = 0;
    repeat (frameLen) begin
      @(negedge clk);
      if (pwmLeft || pwmRight) highs++;
    end
    chk(highs == 0, "R4 zero level stays low", highs, 0);
    endRun("R4 caseE");

    // case F: soft reset overrides enable (R2)
    present(16'h7000, 16'h7000);
    ctrlWord = EN | SR | 32'd1;
    highs = 0;
    repeat (300) begin
      @(negedge clk);
      if (pwmLeft || pwmRight) highs++;
    end
    chk(highs == 0, "R2 soft reset holds low", highs, 0);
    ctrlWord = '0;
    @(negedge clk);
    startRun(EN | 32'd1, 16'h7000, 16'h7000);
    endRun("R2 after soft reset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule